// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block gathers the completion and error events of a bridge DMA engine that serves a USB shared buffer and two audio ports. Each of its ten event inputs is a one-cycle pulse. Every pulse is caught in a sticky status flag, and each flag has its own enable flag. All twenty flags sit in a single 32-bit control/status word, which software reads and writes through a simple strobe port.

The events drive three level interrupt lines, grouped by kind rather than by source. One line carries the address error. One carries every "whole transfer finished" event. One carries every "half buffer reached" event. A service routine reads the word, writes it back with the status flags forced to zero to acknowledge, and then handles each bit that is both set and enabled. Status flags stay readable while masked, so software can also poll them.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status and enable flag is 0, all three interrupt outputs are 0 and a read returns 0x00000000.
- R2: Each event pulse sets its status flag whether or not the event is enabled. Event 0 (USB done) uses word bit 0, event 1 (USB address error) uses bit 1, and audio event n (2..9) uses bit n+14. The order of events 2..9 is port 0 play full, port 0 play half, port 0 record full, port 0 record half, then the same four for port 1.
- R3: A write with 0 in a status bit position clears that flag. A write with 1 there leaves the flag unchanged.
- R4: An event pulse in the same cycle as a write that clears its flag leaves the flag set.
- R5: A write loads every enable flag from its bit. Event 0 uses bit 8, event 1 uses bit 9, and audio event n uses bit n+22. The enable flags read back at those positions.
- R6: Bits 15:10 and 7:2 always read 0, and writes to them have no effect.
- R7: irq_o[0] is driven only by event 1.
- R8: irq_o[1] is driven by events 0, 2, 4, 6 and 8.
- R9: irq_o[2] is driven by events 3, 5, 7 and 9.
- R10: An event whose enable flag is 0 does not drive its interrupt line, even while its status flag is set.
- R11: Each interrupt line is a registered OR of (status AND enable) over its group. It changes one clock after the flags change, and it falls one clock after the last contributing flag is cleared or masked.
- R12: reg_rdata_o shows the word one clock after reg_rd_i, as it stood before any write in that same cycle, and it holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 10 | One-cycle event pulses, index = event number |
| reg_wr_i | input | 1 | Write strobe for the control/status word |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Read data, valid one clock after the strobe |
| irq_o | output | 3 | Level interrupts: [0] error, [1] transfer end, [2] half transfer |

## Verification
The hardest case to reach is a new event that lands in the very cycle its flag is being acknowledged. The stimulus therefore drives the event pulse and the clearing write on the same clock edge, with the flag already set, and then reads the word back. A second hard case is a flag that stays set while its line is masked. The stimulus sets a flag, masks it while writing 1 to the status bit, then watches the line fall, reads the flag back as still set, and re-enables the event to see the line rise again. A write and a read in the same cycle is also driven, to pin down which value the read returns.

// File: rtl/evtagg_pkg.sv
`timescale 1ns/1ps
package evtagg_pkg;
   localparam int EVT_N = 10;
   localparam int IRQ_N = 3;
   localparam int REG_W = 32;

   // position of the sticky status flag of event e
   function automatic int stat_bit(input int e);
      return (e < 2) ? e : e + 14;
   endfunction

   // position of the enable flag of event e
   function automatic int en_bit(input int e);
      return (e < 2) ? e + 8 : e + 22;
   endfunction

   // interrupt line of event e: 0 error, 1 transfer end, 2 half transfer
   function automatic int grp_of(input int e);
      if (e == 1) return 0;
      if (e == 0 || (e % 2) == 0) return 1;
      return 2;
   endfunction

   function automatic logic [EVT_N-1:0] grp_mask(input int g);
      logic [EVT_N-1:0] m;
      m = '0;
      for (int e = 0; e < EVT_N; e++)
         if (grp_of(e) == g) m[e] = 1'b1;
      return m;
   endfunction

   function automatic logic [REG_W-1:0] used_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int e = 0; e < EVT_N; e++) begin
         m[stat_bit(e)] = 1'b1;
         m[en_bit(e)]   = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/evt_flag_bank.sv
`timescale 1ns/1ps
module evt_flag_bank #(
   parameter int EVT_N = evtagg_pkg::EVT_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] evt_i,
   input  logic [EVT_N-1:0] clr_i,
   input  logic             en_we_i,
   input  logic [EVT_N-1:0] en_d_i,
   output logic [EVT_N-1:0] stat_o,
   output logic [EVT_N-1:0] en_o
);
   for (genvar i = 0; i < EVT_N; i++) begin : g_flag
      // an event beats a same-cycle acknowledge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          stat_o[i] <= 1'b0;
         else if (evt_i[i])   stat_o[i] <= 1'b1;
         else if (clr_i[i])   stat_o[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       en_o[i] <= 1'b0;
         else if (en_we_i) en_o[i] <= en_d_i[i];
      end
   end
endmodule

// File: rtl/evt_irq_merge.sv
`timescale 1ns/1ps
module evt_irq_merge #(
   parameter int EVT_N   = evtagg_pkg::EVT_N,
   parameter int IRQ_N   = evtagg_pkg::IRQ_N,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] stat_i,
   input  logic [EVT_N-1:0] en_i,
   output logic [IRQ_N-1:0] irq_o
);
   import evtagg_pkg::*;

   logic [EVT_N-1:0] live;
   assign live = stat_i & en_i;

   for (genvar g = 0; g < IRQ_N; g++) begin : g_line
      logic hit;
      assign hit = |(live & grp_mask(g));

      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o[g] <= 1'b0;
            else        irq_o[g] <= hit;
         end
      end else begin : g_comb
         assign irq_o[g] = hit;
      end
   end
endmodule

// File: rtl/evt_irq_agg.sv
`timescale 1ns/1ps
module evt_irq_agg #(
   parameter int REG_W   = evtagg_pkg::REG_W,
   parameter int EVT_N   = evtagg_pkg::EVT_N,
   parameter int IRQ_N   = evtagg_pkg::IRQ_N,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] evt_pulse_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   input  logic             reg_rd_i,
   output logic [REG_W-1:0] reg_rdata_o,
   output logic [IRQ_N-1:0] irq_o
);
   import evtagg_pkg::*;

   // the bit layout is fixed; these checks stop a mismatched build
   if (REG_W != evtagg_pkg::REG_W) begin : g_bad_w
      $error("evt_irq_agg: REG_W must be %0d", evtagg_pkg::REG_W);
   end
   if (EVT_N != evtagg_pkg::EVT_N) begin : g_bad_e
      $error("evt_irq_agg: EVT_N must be %0d", evtagg_pkg::EVT_N);
   end
   if (IRQ_N != evtagg_pkg::IRQ_N) begin : g_bad_i
      $error("evt_irq_agg: IRQ_N must be %0d", evtagg_pkg::IRQ_N);
   end

   logic [EVT_N-1:0] clr_w, en_d_w, stat_w, en_w;
   logic [REG_W-1:0] word_w;

   // unpack the written word into per-event controls
   for (genvar i = 0; i < EVT_N; i++) begin : g_unpack
      assign clr_w[i]  = reg_wr_i & ~reg_wdata_i[stat_bit(i)];
      assign en_d_w[i] = reg_wdata_i[en_bit(i)];
   end

   evt_flag_bank #(.EVT_N(EVT_N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_pulse_i),
      .clr_i   (clr_w),
      .en_we_i (reg_wr_i),
      .en_d_i  (en_d_w),
      .stat_o  (stat_w),
      .en_o    (en_w)
   );

   evt_irq_merge #(.EVT_N(EVT_N), .IRQ_N(IRQ_N), .IRQ_REG(IRQ_REG)) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_w),
      .en_i   (en_w),
      .irq_o  (irq_o)
   );

   // pack flags back into the word; unused bits stay zero
   always_comb begin
      word_w = '0;
      for (int i = 0; i < EVT_N; i++) begin
         word_w[stat_bit(i)] = stat_w[i];
         word_w[en_bit(i)]   = en_w[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        reg_rdata_o <= '0;
      else if (reg_rd_i) reg_rdata_o <= word_w;
   end
endmodule

// File: rtl/evt_irq_agg_chk.sv
`timescale 1ns/1ps
module evt_irq_agg_chk #(
   parameter int REG_W   = evtagg_pkg::REG_W,
   parameter int EVT_N   = evtagg_pkg::EVT_N,
   parameter int IRQ_N   = evtagg_pkg::IRQ_N,
   parameter bit IRQ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [EVT_N-1:0] evt_pulse_i,
   input logic             reg_wr_i,
   input logic [REG_W-1:0] reg_wdata_i,
   input logic             reg_rd_i,
   input logic [REG_W-1:0] reg_rdata_o,
   input logic [IRQ_N-1:0] irq_o,
   input logic [EVT_N-1:0] stat,
   input logic [EVT_N-1:0] en
);
   import evtagg_pkg::*;

   for (genvar i = 0; i < EVT_N; i++) begin : g_evt
      AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse_i[i] |=> stat[i]); // R2
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr_i && !reg_wdata_i[stat_bit(i)] && !evt_pulse_i[i]) |=> !stat[i]); // R3
      AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[i] && !(reg_wr_i && !reg_wdata_i[stat_bit(i)])) |=> stat[i]); // R3
      AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr_i && evt_pulse_i[i]) |=> stat[i]); // R4
      AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         reg_wr_i |=> (en[i] == $past(reg_wdata_i[en_bit(i)]))); // R5
   end

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_i |=> ((reg_rdata_o & ~used_mask()) == '0)); // R6
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |=> $stable(reg_rdata_o)); // R12

   if (IRQ_REG) begin : g_reg_chk
      for (genvar g = 0; g < IRQ_N; g++) begin : g_line
         AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ((stat & en & grp_mask(g)) == '0) |=> !irq_o[g]); // R10
         AST_LINE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
            ((stat & en & grp_mask(g)) != '0) |=> irq_o[g]); // R11
      end
   end
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
   .REG_W(REG_W), .EVT_N(EVT_N), .IRQ_N(IRQ_N), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_pulse_i (evt_pulse_i),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rd_i    (reg_rd_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .stat        (stat_w),
   .en          (en_w)
);

// File: tb/evt_irq_agg_test.sv
`timescale 1ns/1ps
module evt_irq_agg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  evt = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;
   exp_t sb_q[$];
   logic rd_d = 1'b0;

   localparam logic [31:0] ALL_EN = 32'hFF00_0300;

   always #4 clk = ~clk;

   evt_irq_agg uut (
      .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt),
      .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   // monitor: read data appears the clock after the strobe
   always @(posedge clk) rd_d <= rd;
   always @(negedge clk) begin
      if (rd_d) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read data: actual %h expected none", rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (rdata !== e.val) begin
               errors++;
               $display("FAIL %s: rdata actual %h expected %h", e.tag, rdata, e.val);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr_word(input logic [31:0] d);
      wr = 1'b1; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_word(input logic [31:0] exp, input string tag);
      exp_t e;
      e.val = exp; e.tag = tag;
      sb_q.push_back(e);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic wr_rd(input logic [31:0] d, input logic [31:0] exp, input string tag);
      exp_t e;
      e.val = exp; e.tag = tag;
      sb_q.push_back(e);
      wr = 1'b1; wdata = d; rd = 1'b1;
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic pulse(input logic [9:0] m);
      evt = m;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic wr_pulse(input logic [31:0] d, input logic [9:0] m);
      wr = 1'b1; wdata = d; evt = m;
      @(negedge clk);
      wr = 1'b0; evt = '0;
   endtask

   task automatic chk_irq(input logic [2:0] exp, input string tag);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
      end
   endtask

   // one event alone reaches exactly its own line, then is acknowledged
   task automatic grp_case(input int ev, input logic [2:0] exp, input string tag);
      pulse(10'(1) << ev);
      tick();
      chk_irq(exp, tag);
      wr_word(ALL_EN);
      tick();
      chk_irq(3'b000, {tag, " ack"});
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk_irq(3'b000, "R1 reset irq");
      rd_word(32'h0, "R1 reset word");

      // all events while masked: status visible, no line
      pulse(10'h3FF);
      tick();
      chk_irq(3'b000, "R10 masked events");
      rd_word(32'h00FF_0003, "R2 status positions");

      // enable all, write ones to status and unused bits
      wr_word(32'hFFFF_FFFF);
      chk_irq(3'b000, "R11 one-clock lag on enable");
      rd_word(32'hFFFF_0303, "R3 R5 R6 ones write");
      chk_irq(3'b111, "R7 R8 R9 all lines");

      wr_word(ALL_EN);
      chk_irq(3'b111, "R11 lag on ack");
      tick();
      chk_irq(3'b000, "R11 falls after ack");
      rd_word(ALL_EN, "R3 acked word");

      grp_case(1, 3'b001, "R7 event1");
      grp_case(0, 3'b010, "R8 event0");
      grp_case(2, 3'b010, "R8 event2");
      grp_case(8, 3'b010, "R8 event8");
      grp_case(3, 3'b100, "R9 event3");
      grp_case(9, 3'b100, "R9 event9");

      // mask a set flag, keep the status with a 1
      pulse(10'(1) << 5);
      tick();
      chk_irq(3'b100, "R9 event5");
      wr_word(32'hF708_0300);
      tick();
      chk_irq(3'b000, "R10 masked while set");
      rd_word(32'hF708_0300, "R2 poll masked flag");
      wr_word(32'hFF08_0300);
      tick();
      chk_irq(3'b100, "R11 re-enable");
      wr_word(ALL_EN);
      tick();

      // event meets its own acknowledge
      pulse(10'(1) << 4);
      wr_pulse(ALL_EN, 10'(1) << 4);
      rd_word(32'hFF04_0300, "R4 event wins ack");
      chk_irq(3'b010, "R4 R8 line stays");
      wr_word(ALL_EN);
      tick();

      // write and read in one cycle
      wr_rd(32'h0, ALL_EN, "R12 read before write");
      rd_word(32'h0, "R12 write landed");
      tick();
      checks++;
      if (rdata !== 32'h0) begin
         errors++;
         $display("FAIL R12 hold: rdata actual %h expected %h", rdata, 32'h0);
      end

      // selective acknowledge
      wr_word(ALL_EN);
      pulse(10'h041);
      wr_word(32'hFF10_0300);
      rd_word(32'hFF10_0300, "R3 selective clear");
      chk_irq(3'b010, "R3 R8 remaining flag");

      // reset mid-run
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      chk_irq(3'b000, "R1 re-reset irq");
      rd_word(32'h0, "R1 re-reset word");

      tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule